// File: doc/BRIEF.md
# Bitfield Extract Alias Classifier

This block decides whether a bitfield-move instruction is best shown as a bitfield-extract alias. A disassembly or trace unit uses it for that choice. It takes the operand-size flag, the signed/unsigned flag and the two 6-bit immediates of the instruction. It returns one bit: high when the extract form is the preferred rendering.

The decision works by ruling out more specific aliases. An instruction is excluded when its immediates match one of the following:

- the insert-into-zero form, where the top-bit field is below the rotate field;
- a plain shift, where the top-bit field is at the last bit of the operand;
- a zero or sign extension of a byte, halfword or word, where the rotate field is zero and the top-bit field marks one of those widths.

Any instruction not excluded keeps the extract form.

The result and a valid flag pass through one register stage by default. A parameter can remove that stage for a purely combinational variant.

Top module: `bfx_alias_classifier`

## Requirements
- R1: When the top-bit field (`i_top`) is numerically smaller than the rotate field (`i_rot`), `o_pref` is 0.
- R2: When `i_top` equals `{i_wide, 5'b11111}`, `o_pref` is 0. This is 31 for 32-bit operands (`i_wide`=0) and 63 for 64-bit operands (`i_wide`=1).
- R3: When `i_rot` is 0, `i_wide` is 0 and `i_top` is 7 or 15, `o_pref` is 0, whatever `i_zext` is.
- R4: When `i_rot` is 0, `i_wide` is 1, `i_zext` is 0 and `i_top` is 7, 15 or 31, `o_pref` is 0.
- R5: When `i_rot` is 0, `i_wide` is 1 and `i_zext` is 1, the extension exclusion does not apply. For example, `i_top` of 7, 15 or 31 gives `o_pref` = 1.
- R6: When none of the exclusions in R1 to R4 applies, `o_pref` is 1.
- R7: With the default registered variant, the result and `o_valid` appear on the rising clock edge after the inputs are presented. `o_valid` copies `i_valid` from that edge.
- R8: A synchronous active-high reset clears `o_valid` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Input qualifier |
| i_wide | input | 1 | 1 for a 64-bit operand, 0 for a 32-bit operand |
| i_zext | input | 1 | 1 for the unsigned form, 0 for the signed form |
| i_top | input | 6 | Top-bit immediate field |
| i_rot | input | 6 | Rotate immediate field |
| o_valid | output | 1 | Registered copy of `i_valid` |
| o_pref | output | 1 | 1 when the extract alias is preferred |

## Verification
On every cycle, the assertions check these behaviours:
- each exclusion (insert, shift, 32-bit extension and 64-bit signed extension) forces the registered result low one edge later;
- `o_valid` tracks `i_valid` with one cycle of delay;
- a reset clears `o_valid`.

Only the bench can show that an excluded pattern does not spill into a neighbouring one, and that unexcluded encodings come out high. It sweeps all 16384 combinations of the four inputs and checks each one against an independently computed expectation. It also runs directed cases for the 64-bit unsigned encodings that must stay preferred.

// File: rtl/bfx_alias_pkg.sv
package bfx_alias_pkg;
   // Exclusion flags raised by the detector units
   typedef struct packed {
      logic insert_hit;
      logic shift_hit;
      logic extend_hit;
   } bfx_excl_t;

   // Smallest immediate width that can express the extension codes
   localparam int unsigned BFX_MIN_IMM_W = 6;
   // log2 of the narrowest extended element (a byte)
   localparam int unsigned BFX_EXT_MIN_LOG = 3;

   function automatic logic bfx_any_excl(input bfx_excl_t f);
      return f.insert_hit | f.shift_hit | f.extend_hit;
   endfunction
endpackage

// File: rtl/bfx_insert_detect.sv
module bfx_insert_detect #(
   parameter int unsigned IMM_W = 6
) (
   input  logic [IMM_W-1:0] top_fld,
   input  logic [IMM_W-1:0] rot_fld,
   output logic             hit
);
   // Insert-into-zero form: the field top lies below the rotate amount
   always_comb begin
      hit = (top_fld < rot_fld);
   end
endmodule

// File: rtl/bfx_shift_detect.sv
module bfx_shift_detect #(
   parameter int unsigned IMM_W = 6
) (
   input  logic             wide,
   input  logic [IMM_W-1:0] top_fld,
   output logic             hit
);
   localparam int unsigned LOW_W = IMM_W - 1;
   logic [IMM_W-1:0] last_bit_code;

   // The top field at the last operand bit means a shift alias
   always_comb begin
      last_bit_code = {wide, {LOW_W{1'b1}}};
      hit           = (top_fld == last_bit_code);
   end
endmodule

// File: rtl/bfx_extend_detect.sv
module bfx_extend_detect #(
   parameter int unsigned IMM_W   = 6,
   parameter int unsigned MIN_LOG = 3
) (
   input  logic             wide,
   input  logic             zext,
   input  logic [IMM_W-1:0] top_fld,
   input  logic [IMM_W-1:0] rot_fld,
   output logic             hit
);
   // Element sizes 2^MIN_LOG .. 2^(IMM_W-1); the last is the word size
   localparam int unsigned WORD_LOG = IMM_W - 1;
   localparam int unsigned N_EXT    = WORD_LOG - MIN_LOG + 1;

   logic [N_EXT-1:0] code_hit;
   logic             rot_zero;

   generate
      for (genvar k = 0; k < N_EXT; k++) begin : g_code
         localparam int unsigned LOG_K = MIN_LOG + k;
         localparam logic [IMM_W-1:0] CODE_K = IMM_W'((64'd1 << LOG_K) - 64'd1);
         logic code_match;
         assign code_match = (top_fld == CODE_K);
         if (LOG_K == WORD_LOG) begin : g_word
            // Word extension exists only as a 64-bit signed form
            assign code_hit[k] = code_match & wide & ~zext;
         end else begin : g_narrow
            // Byte/halfword: any 32-bit form, or 64-bit signed form
            assign code_hit[k] = code_match & (~wide | ~zext);
         end
      end
   endgenerate

   always_comb begin
      rot_zero = (rot_fld == '0);
      hit      = rot_zero & (|code_hit);
   end
endmodule

// File: rtl/bfx_alias_classifier.sv
module bfx_alias_classifier #(
   parameter int unsigned IMM_W   = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             i_valid,
   input  logic             i_wide,
   input  logic             i_zext,
   input  logic [IMM_W-1:0] i_top,
   input  logic [IMM_W-1:0] i_rot,
   output logic             o_valid,
   output logic             o_pref
);
   import bfx_alias_pkg::*;

   generate
      if (IMM_W < BFX_MIN_IMM_W) begin : g_bad_width
         $error("bfx_alias_classifier: IMM_W must be at least %0d", BFX_MIN_IMM_W);
      end
   endgenerate

   bfx_excl_t excl;
   logic      pref_next;

   bfx_insert_detect #(.IMM_W(IMM_W)) u_insert (
      .top_fld (i_top),
      .rot_fld (i_rot),
      .hit     (excl.insert_hit)
   );

   bfx_shift_detect #(.IMM_W(IMM_W)) u_shift (
      .wide    (i_wide),
      .top_fld (i_top),
      .hit     (excl.shift_hit)
   );

   bfx_extend_detect #(.IMM_W(IMM_W), .MIN_LOG(BFX_EXT_MIN_LOG)) u_extend (
      .wide    (i_wide),
      .zext    (i_zext),
      .top_fld (i_top),
      .rot_fld (i_rot),
      .hit     (excl.extend_hit)
   );

   always_comb begin
      pref_next = ~bfx_any_excl(excl);
   end

   generate
      if (REG_OUT) begin : g_reg
         logic valid_q;
         logic pref_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               valid_q <= 1'b0;
            end else begin
               valid_q <= i_valid;
            end
            pref_q <= pref_next;
         end
         assign o_valid = valid_q;
         assign o_pref  = pref_q;
      end else begin : g_comb
         assign o_valid = i_valid;
         assign o_pref  = pref_next;
      end
   endgenerate
endmodule

// File: rtl/bfx_alias_chk.sv
module bfx_alias_chk #(
   parameter int unsigned IMM_W   = 6,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             i_valid,
   input logic             i_wide,
   input logic             i_zext,
   input logic [IMM_W-1:0] i_top,
   input logic [IMM_W-1:0] i_rot,
   input logic             o_valid,
   input logic             o_pref
);
   localparam logic [IMM_W-1:0] C_BYTE = IMM_W'(7);
   localparam logic [IMM_W-1:0] C_HALF = IMM_W'(15);
   localparam logic [IMM_W-1:0] C_WORD = IMM_W'(31);

   generate
      if (REG_OUT) begin : g_reg_props
         p_insert_excl_r1: assert property (@(posedge clk) disable iff (rst)
            (i_top < i_rot) |=> !o_pref);

         p_shift_excl_r2: assert property (@(posedge clk) disable iff (rst)
            (i_top == {i_wide, {(IMM_W-1){1'b1}}}) |=> !o_pref);

         p_ext32_excl_r3: assert property (@(posedge clk) disable iff (rst)
            ((i_rot == '0) && !i_wide && ((i_top == C_BYTE) || (i_top == C_HALF)))
            |=> !o_pref);

         p_ext64_excl_r4: assert property (@(posedge clk) disable iff (rst)
            ((i_rot == '0) && i_wide && !i_zext &&
             ((i_top == C_BYTE) || (i_top == C_HALF) || (i_top == C_WORD)))
            |=> !o_pref);

         p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
            i_valid |=> o_valid);

         p_valid_drop_r7: assert property (@(posedge clk) disable iff (rst)
            !i_valid |=> !o_valid);

         // R8: one edge after reset is seen, o_valid must be low
         logic rst_seen_q = 1'b0;
         always @(posedge clk) rst_seen_q <= rst;
         always @(negedge clk) begin
            if (rst_seen_q) begin
               p_reset_clear_r8: assert (!o_valid);
            end
         end
      end
   endgenerate
endmodule

bind bfx_alias_classifier bfx_alias_chk #(.IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .i_valid (i_valid),
   .i_wide  (i_wide),
   .i_zext  (i_zext),
   .i_top   (i_top),
   .i_rot   (i_rot),
   .o_valid (o_valid),
   .o_pref  (o_pref)
);

// File: tb/tb_bfx_alias_classifier.sv
module tb_bfx_alias_classifier;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       i_valid = 1'b0;
   logic       i_wide = 1'b0;
   logic       i_zext = 1'b0;
   logic [5:0] i_top = '0;
   logic [5:0] i_rot = '0;
   logic       o_valid;
   logic       o_pref;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bfx_alias_classifier dut (
      .clk     (clk),
      .rst     (rst),
      .i_valid (i_valid),
      .i_wide  (i_wide),
      .i_zext  (i_zext),
      .i_top   (i_top),
      .i_rot   (i_rot),
      .o_valid (o_valid),
      .o_pref  (o_pref)
   );

   // Requirement that decides the expected result, first rule wins
   function automatic string rule_of(bit w, bit z, int top, int rot);
      int elem;
      if (top < rot) return "R1";
      if (top == 31 + 32 * w) return "R2";
      elem = top + 1;
      if (rot == 0 && !w && (elem == 8 || elem == 16)) return "R3";
      if (rot == 0 && w && !z && (elem == 8 || elem == 16 || elem == 32)) return "R4";
      if (rot == 0 && w && z) return "R5";
      return "R6";
   endfunction

   function automatic bit expect_pref(string r);
      return (r == "R5" || r == "R6");
   endfunction

   task automatic check(string req, int act, int exp, string what);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, WATCHDOG);
         finish_run();
      end
   end

   // Drive at a falling edge, check at the next falling edge (one register)
   task automatic apply_and_check(bit v, bit w, bit z, int top, int rot);
      string r;
      @(negedge clk);
      i_valid = v; i_wide = w; i_zext = z;
      i_top = 6'(top); i_rot = 6'(rot);
      r = rule_of(w, z, top, rot);
      @(negedge clk);
      check(r, int'(o_pref), int'(expect_pref(r)), "pref");
      check("R7", int'(o_valid), int'(v), "valid");
   endtask

   initial begin
      // R8: reset state
      repeat (2) @(negedge clk);
      check("R8", int'(o_valid), 0, "valid under reset");
      rst = 1'b0;

      // Directed: R5 64-bit unsigned extension codes stay preferred
      apply_and_check(1'b1, 1'b1, 1'b1, 7, 0);
      apply_and_check(1'b1, 1'b1, 1'b1, 15, 0);
      apply_and_check(1'b1, 1'b1, 1'b1, 31, 0);
      // Directed: R4 signed word, R3 32-bit unsigned halfword, R2, R1
      apply_and_check(1'b1, 1'b1, 1'b0, 31, 0);
      apply_and_check(1'b1, 1'b0, 1'b1, 15, 0);
      apply_and_check(1'b1, 1'b0, 1'b0, 31, 3);
      apply_and_check(1'b1, 1'b1, 1'b0, 4, 5);
      apply_and_check(1'b1, 1'b0, 1'b0, 7, 1);

      // Exhaustive sweep over all 2^14 input combinations
      for (int i = 0; i < 16384; i++) begin
         apply_and_check(bit'(i[0] ^ i[7]), bit'(i[13]), bit'(i[12]),
                         (i >> 6) & 63, i & 63);
      end

      // R8: mid-run reset with valid held high
      @(negedge clk);
      i_valid = 1'b1;
      @(negedge clk);
      check("R7", int'(o_valid), 1, "valid before reset");
      rst = 1'b1;
      @(negedge clk);
      check("R8", int'(o_valid), 0, "valid after reset");
      rst = 1'b0;
      @(negedge clk);
      check("R7", int'(o_valid), 1, "valid after release");

      finish_run();
   end
endmodule